// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a bus target for a two-wire serial link that sits in front of a byte-wide storage array of 128 to 2048 bytes. It works in the system clock domain. The sampled clock line and data line go through synchronizers and an edge detector. The block drives only a pull-down enable for the shared, open-drain data line. Hard-wired address pins set the target's identity on the bus, and a write-protect input can lock the whole array.

A host starts a transfer and sends a device word. For a write, the host then sends a word address and one or more data bytes. Data bytes are collected in a page buffer. They are committed to the array only when a stop arrives on a byte boundary, and only after a programmable busy interval. During that interval the target ignores its own address, so the host can poll for completion. Reads come in three forms: from the internal address pointer, after a dummy write that loads a new address, or as a stream that continues while the host keeps acknowledging.

Top module: `eeprom_target`

## Requirements
- R1: A data-line fall while the clock line is high (start) always restarts device-word reception. A data-line rise while the clock line is high (stop) returns the target to idle with the data line released. While idle, clocked bits are ignored until the next start.
- R2: The device word is accepted only when its upper four bits are 1010 and its pin-match bits equal the address pins. The pin-match bits are bit 3 vs pin 2, bit 2 vs pin 1 and bit 1 vs pin 0. Bit 0 selects read (1) or write (0). An accepted word is acknowledged by pulling the data line low during the ninth clock. A rejected word gets no acknowledge, and the target waits for a new start.
- R3: Arrays of 512, 1024 and 2048 bytes use device-word bits 1, 2..1 and 3..1 respectively as address bits 8 and up, in place of pin matching. For the default 512-byte array, bit 1 is address bit 8, and pins 2 and 1 are still compared.
- R4: In a write, the word address and every data byte are acknowledged. A stop on a byte boundary after at least one data byte starts a busy interval of BUSY_CYCLES clocks. The buffered bytes reach the array when that interval ends.
- R5: The page is 8 bytes for arrays of 256 bytes or fewer, and 16 bytes otherwise. During a write only the in-page address bits advance, so bytes past the page end wrap to the page start and overwrite earlier bytes.
- R6: While the busy interval runs, no device word is acknowledged. The first one acknowledged after it ends, read or write, is served normally.
- R7: The address pointer holds the last accessed address plus one. A read with no address phase starts at that pointer.
- R8: A dummy write (device word and word address, then a repeated start) loads the pointer. The read that follows returns the byte at the loaded address.
- R9: A read streams consecutive bytes while the host acknowledges each one, rolling over from the last array byte to address 0. The target releases the data line during the host's acknowledge bit. A host non-acknowledge followed by a stop ends the read.
- R10: With write protect high, data bytes are still acknowledged, but the array does not change and no busy interval starts.
- R11: A start or stop in the middle of a data byte discards the whole write. Nothing is committed and no busy interval starts.
- R12: After reset the data line is released, every array byte reads 0xFF and the address pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (wired level) |
| pin_addr | input | 3 | Hard-wired target address pins |
| wp_i | input | 1 | Write protect, high locks the whole array |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain data line |

## Verification
The assertions watch, on every cycle, the invariants that span the line detector, the protocol sequencer and the busy timer:
- a stop leaves the target idle with the line released;
- the target never acknowledges a device word while busy;
- the busy interval starts only from a write data phase with protect low;
- the line stays released during the host's acknowledge bit.

Only the bench's bus scenarios can show the data behaviour. That covers page wrap, array rollover, the upper address bit carried in the device word, pointer continuity across reads, and that polling succeeds only after the interval ends. It also covers that protected or aborted writes leave the array untouched.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  // bytes per write page for a given array size
  function automatic int page_bytes(int mem_bytes);
    return (mem_bytes <= 256) ? 8 : 16;
  endfunction

  // how many device-word bits carry upper address bits
  function automatic int dev_addr_bits(int mem_bytes);
    if (mem_bytes > 1024) return 3;
    if (mem_bytes > 512)  return 2;
    if (mem_bytes > 256)  return 1;
    return 0;
  endfunction

  // next address inside the same page
  function automatic int page_step(int a, int pg);
    return a - (a % pg) + ((a % pg) + 1) % pg;
  endfunction

  // next address across the whole array
  function automatic int array_step(int a, int n);
    return (a + 1) % n;
  endfunction

endpackage

// File: rtl/ee_line_events.sv
module ee_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_now
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  assign scl_now  = scl_sy[1];
  assign sda_now  = sda_sy[1];
  assign scl_rise = scl_now & ~scl_d;
  assign scl_fall = ~scl_now & scl_d;
  assign start_ev = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_ev  = scl_now & scl_d & ~sda_d & sda_now;

endmodule

// File: rtl/ee_write_timer.sv
module ee_write_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (launch)     cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  assert_launch_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
  assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
  import ee_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] pin_addr,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int PAGE = page_bytes(MEM_BYTES);
  localparam int PW   = $clog2(PAGE);
  localparam int RW   = AW - PW;
  localparam int UPB  = dev_addr_bits(MEM_BYTES);
  localparam logic [2:0] UP_MASK = 3'((1 << UPB) - 1);

  // line events
  logic scl_rise, scl_fall, start_ev, stop_ev, sda_now;
  ee_line_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_now(sda_now)
  );

  ee_state_t   state;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, tx;
  logic [AW-1:0] addr_ptr;
  logic [2:0]  dev_page;
  logic        dev_rd, host_ack, got_data, pull;
  logic [7:0]  pbuf [PAGE];
  logic [PAGE-1:0] pvalid;
  logic [RW-1:0] pg_row;
  logic [7:0]  mem [MEM_BYTES];

  // named internal events
  logic byte_done, pins_ok, dev_match, launch, busy, commit;
  logic [AW-1:0] word_addr;
  logic [7:0]    rd_byte;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign rd_byte   = mem[addr_ptr];

  always_comb begin
    pins_ok = 1'b1;
    for (int k = 0; k < 3; k++)
      if (k >= UPB && shreg[k+1] != pin_addr[k]) pins_ok = 1'b0;
  end

  assign dev_match = (shreg[7:4] == DEV_PREFIX) && pins_ok && !busy;
  assign word_addr = AW'((int'(dev_page) << 8) + int'(shreg));
  assign launch    = stop_ev && (state == ST_WDATA) && (bitcnt <= 4'd1)
                     && got_data && !wp_i && !busy;

  ee_write_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .done(commit)
  );

  // protocol sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '0;
      addr_ptr <= '0;
      dev_page <= '0;
      dev_rd   <= 1'b0;
      host_ack <= 1'b0;
      got_data <= 1'b0;
      pull     <= 1'b0;
      pvalid   <= '0;
      pg_row   <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
    end else begin
      if (commit) pvalid <= '0;
      if (start_ev) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        pull   <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        pull   <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_now};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (dev_match) begin
                  pull     <= 1'b1;
                  dev_rd   <= shreg[0];
                  dev_page <= shreg[3:1] & UP_MASK;
                  state    <= ST_DEV_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_WADDR) begin
                addr_ptr <= word_addr;
                pg_row   <= word_addr[AW-1:PW];
                pvalid   <= '0;
                got_data <= 1'b0;
                pull     <= 1'b1;
                state    <= ST_WADDR_ACK;
              end else begin
                pbuf[addr_ptr[PW-1:0]]   <= shreg;
                pvalid[addr_ptr[PW-1:0]] <= 1'b1;
                got_data <= 1'b1;
                addr_ptr <= AW'(page_step(int'(addr_ptr), PAGE));
                pull     <= 1'b1;
                state    <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            if (dev_rd) begin
              tx       <= rd_byte;
              pull     <= ~rd_byte[7];
              addr_ptr <= AW'(array_step(int'(addr_ptr), MEM_BYTES));
              bitcnt   <= '0;
              state    <= ST_RDATA;
            end else begin
              pull  <= 1'b0;
              state <= ST_WADDR;
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            pull  <= 1'b0;
            state <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                pull  <= 1'b0;
                state <= ST_RACK;
              end else begin
                tx   <= {tx[6:0], 1'b0};
                pull <= ~tx[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) host_ack <= ~sda_now;
            else if (scl_fall) begin
              if (host_ack) begin
                tx       <= rd_byte;
                pull     <= ~rd_byte[7];
                addr_ptr <= AW'(array_step(int'(addr_ptr), MEM_BYTES));
                bitcnt   <= '0;
                state    <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // storage array, committed from the page buffer at the end of busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pvalid[i]) mem[{pg_row, PW'(i)}] <= pbuf[i];
    end
  end

  assign sda_pull_o = pull;

  assert_stop_goes_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_pull_o));
  assert_no_ack_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV_ACK) |-> !busy);
  assert_busy_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(state) == ST_WDATA));
  assert_protect_blocks_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i));
  assert_release_host_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> !sda_pull_o);

endmodule

// File: tb/eeprom_target_tb_top.sv
`timescale 1ns/1ps
module eeprom_target_tb_top;
  localparam int N    = 512;
  localparam int BUSY = 400;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_sda = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sda_pull;
  logic line;
  assign line = host_sda & ~sda_pull;

  eeprom_target #(.MEM_BYTES(N), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .pin_addr(pins), .wp_i(wp), .sda_pull_o(sda_pull)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mem_m [N];
  int ptr_m = 0;
  bit quiet = 1'b0;
  logic [7:0] wq [$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock model check: target must leave the line alone while host owns it
  always @(posedge clk) begin
    #1;
    if (rst_n && quiet && scl) chk(sda_pull == 1'b0, "R9 line released in host bit", sda_pull, 0);
  end

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_phase(input bit b, output bit r, input bit host_owns);
    host_sda = b; quiet = host_owns; w(8);
    scl = 1'b1; w(4); r = line; w(4);
    scl = 1'b0; quiet = 1'b0; w(8);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; w(4); scl = 1'b1; w(8); host_sda = 1'b0; w(8); scl = 1'b0; w(8);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; w(8); scl = 1'b1; w(8); host_sda = 1'b1; w(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_phase(b[i], r, 1'b1);
    bit_phase(1'b1, r, 1'b0);
    ack = !r;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit r;
    for (int i = 0; i < 8; i++) begin bit_phase(1'b1, r, 1'b0); d = {d[6:0], r}; end
    bit_phase(!give_ack, r, 1'b1);
  endtask

  function automatic logic [7:0] dev(int addr, bit rd);
    return {4'b1010, pins[2], pins[1], addr[8], rd};
  endfunction

  function automatic int pnext(int a);
    logic [8:0] v = 9'(a);
    v[3:0] = v[3:0] + 4'd1;
    return int'(v);
  endfunction

  task automatic write_seq(int addr, string tag);
    bit ack;
    int a = addr;
    bus_start();
    send_byte(dev(addr, 0), ack); chk(ack, {tag, " dev ack"}, ack, 1);
    send_byte(addr[7:0], ack);    chk(ack, {tag, " word ack R4"}, ack, 1);
    foreach (wq[i]) begin
      send_byte(wq[i], ack); chk(ack, {tag, " data ack R4"}, ack, 1);
      if (!wp) mem_m[a] = wq[i];
      a = pnext(a);
    end
    ptr_m = a;
    bus_stop();
  endtask

  task automatic poll(output int tries);
    bit ack;
    tries = 0;
    do begin
      tries++;
      bus_start(); send_byte(dev(0, 0), ack); bus_stop();
    end while (!ack && tries < 20);
  endtask

  task automatic read_bytes(int n, string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == mem_m[ptr_m], tag, d, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % N;
    end
    bus_stop();
  endtask

  task automatic read_random(int addr, int n, string tag);
    bit ack;
    bus_start();
    send_byte(dev(addr, 0), ack); chk(ack, {tag, " dev ack R8"}, ack, 1);
    send_byte(addr[7:0], ack);    chk(ack, {tag, " word ack R8"}, ack, 1);
    bus_start();
    send_byte(dev(0, 1), ack);    chk(ack, {tag, " read dev ack R8"}, ack, 1);
    ptr_m = addr;
    read_bytes(n, tag);
  endtask

  task automatic read_current(int n, string tag);
    bit ack;
    bus_start();
    send_byte(dev(0, 1), ack); chk(ack, {tag, " dev ack R7"}, ack, 1);
    read_bytes(n, tag);
  endtask

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack, r;
    int tries;
    for (int i = 0; i < N; i++) mem_m[i] = 8'hFF;
    w(5); rst_n = 1'b1; w(5);

    // R12: reset state
    chk(sda_pull == 1'b0, "R12 line released after reset", sda_pull, 0);
    read_current(1, "R12 erased byte at pointer 0");

    // R2: mismatches are rejected
    bus_start(); send_byte({4'b1010, ~pins[2], pins[1], 2'b00}, ack);
    chk(!ack, "R2 pin mismatch nack", ack, 0);
    bus_start(); send_byte(8'hB4, ack);
    chk(!ack, "R2 prefix mismatch nack", ack, 0);
    // R1: idle ignores a matching word sent without a start
    send_byte(dev(0, 0), ack);
    chk(!ack, "R1 no start no ack", ack, 0);
    bus_stop();

    // R3/R4/R6: byte write with upper address bit, then polling
    wq = '{8'h3C};
    write_seq(9'h1F3, "R4 byte write");
    poll(tries);
    chk(tries >= 2, "R6 first poll during busy nacked", tries, 2);
    chk(tries < 20, "R6 poll eventually acked", tries, 2);
    read_random(9'h1F3, 1, "R3 upper bit read");
    read_random(9'h0F3, 1, "R3 low half untouched");

    // R5: page wrap
    wq = '{8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4};
    write_seq(9'h00E, "R5 page write");
    poll(tries);
    read_random(9'h000, 17, "R5 wrapped page contents");
    read_random(9'h000, 1, "R8 random read");
    read_current(2, "R7 current address read");

    // R9: rollover at array end
    wq = '{8'hAB, 8'hCD, 8'hEF};
    write_seq(9'h1FE, "R5 top page write");
    poll(tries);
    read_random(9'h1FF, 3, "R9 rollover read");
    read_random(9'h1F0, 1, "R5 top page wrap");

    // R10: write protect
    wp = 1'b1;
    wq = '{8'h77};
    write_seq(9'h050, "R10 protected write");
    poll(tries);
    chk(tries == 1, "R10 no busy when protected", tries, 1);
    wp = 1'b0;
    read_random(9'h050, 1, "R10 protected byte unchanged");

    // R11: stop in the middle of a data byte
    bus_start();
    send_byte(dev(9'h060, 0), ack);
    send_byte(8'h60, ack);
    send_byte(8'h11, ack); chk(ack, "R11 first data ack", ack, 1);
    for (int i = 0; i < 4; i++) bit_phase(1'b1, r, 1'b1);
    bus_stop();
    poll(tries);
    chk(tries == 1, "R11 no busy after abort", tries, 1);
    read_random(9'h060, 1, "R11 aborted byte unchanged");
    chk(sda_pull == 1'b0, "R1 released after final stop", sda_pull, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule